// File: doc/BRIEF.md
# Nonvolatile Memory Power-State Controller

This block decides when an on-chip nonvolatile memory array is powered. It keeps the array in one of three states: ON (powered and able to serve accesses), OFF (unpowered), and WAKE (powered but still settling). A one-bit power-request register, which software writes, sets the preferred state while the device runs. A memory access request that finds the array unpowered wakes it. Hardware then sets the power-request bit, so the array stays on afterwards.

A device-mode input reports either normal running (code 0) or one of several low-power modes (any nonzero code). A low-power mode forces the array off but leaves the power-request bit unchanged. When the device returns to normal running, the saved bit decides the next step. If it is 1, the array powers up at once. If it is 0, the array stays off until the first access arrives.

Each power-up goes through a WAKE interval of programmable length. During that interval accesses are held off. The requester holds its request high for the whole access. The grant output tells it when the access is being served.

Top module: `nvm_pwr_ctl`

## Requirements
- R1: After reset the power-request bit reads 1, `arr_pwr_en` is 1, and an access request is granted in the same cycle it is raised.
- R2: With `dev_mode` = 0 and the power-request bit at 1, `arr_pwr_en` stays 1 whatever pattern `acc_req` follows.
- R3: A software write of 0 to the power-request bit, with `dev_mode` = 0 and no access pending, takes effect as follows. The bit reads 0 after the next clock edge. `arr_pwr_en` falls after the edge that follows.
- R4: If `acc_req` is high while the array is OFF, the power-request bit reads 1 after the next edge. The array enters WAKE on that same edge.
- R5: If software writes 1 to the power-request bit while the array is OFF and `dev_mode` = 0, `arr_pwr_en` rises one edge after the bit reads 1. No access is needed for this.
- R6: Any nonzero `dev_mode` with `acc_req` low turns `arr_pwr_en` off after the next edge. Without a software write or an access, the power-request bit keeps its value.
- R7: When `dev_mode` returns to 0 and the bit is 1, `arr_pwr_en` rises after the next edge. When the bit is 0, the array stays off until an access arrives.
- R8: The WAKE interval lasts max(`wake_cycles`,1) clock cycles. During it `arr_pwr_en` is 1 and `acc_grant` is 0. `acc_grant` is 1 exactly when the state is ON and `acc_req` is 1. An access that arrives while the array is OFF is therefore first granted max(`wake_cycles`,1)+1 edges after it is raised.
- R9: An access raised during a low-power mode also wakes the array and sets the power-request bit. The low-power mode does not turn the array off while that access is held.
- R10: If software writes 0 to the power-request bit in the same cycle that an access sets it, the bit reads 1.
- R11: While `acc_req` is high in the ON state, the array stays ON even if the bit is 0 or a low-power mode is signalled. The pending transition happens on the first edge after `acc_req` falls.
- R12: If a low-power mode is signalled during WAKE with no access pending, the wake-up is abandoned and `arr_pwr_en` falls after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_mode | input | MODE_W | Device mode: 0 = normal running, nonzero = low-power mode |
| wake_cycles | input | CNT_W | Length of the wake-up interval in cycles (0 behaves as 1) |
| reg_wr_en | input | 1 | Software write strobe for the power-request bit |
| reg_wr_data | input | 1 | Value written to the power-request bit |
| acc_req | input | 1 | Access request, held high for the whole access |
| acc_grant | output | 1 | Access is being served this cycle |
| arr_pwr_en | output | 1 | Array power enable |
| pwr_req_rd | output | 1 | Readback of the power-request bit |

## Verification
The bench builds the block with CNT_W = 3 and MODE_W = 2. With these values it can sweep every wake-up length from 0 to 7, and it can visit every low-power code with both values of the power-request bit. Grant latency is measured cycle by cycle against max(D,1)+1 for access-driven wake-ups and against max(D,1) for software-driven ones. The small sizes keep the same-cycle write/auto-set collision, the deferral under a held access and the abandoned wake-up short enough to run on every configuration.

// File: rtl/nvm_pwr_pkg.sv
package nvm_pwr_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAKE = 2'd1,
        ST_ON   = 2'd2
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e st;
    } fsm_regs_t;

    typedef struct packed {
        logic bit_val;
    } req_regs_t;

endpackage

// File: rtl/nvm_req_bit.sv
module nvm_req_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_wr,
    input  logic sw_val,
    input  logic hw_set,
    output logic bit_q
);
    import nvm_pwr_pkg::*;

    req_regs_t r_d, r_q;

    // hardware auto-set takes priority over a software write in the same cycle
    always_comb begin
        r_d = r_q;
        if (hw_set) begin
            r_d.bit_val = 1'b1;
        end else if (sw_wr) begin
            r_d.bit_val = sw_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.bit_val <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign bit_q = r_q.bit_val;

endmodule

// File: rtl/nvm_wake_timer.sv
module nvm_wake_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load) begin
            t_d.cnt = load_val;
        end else if (run && (t_q.cnt != CNT_ZERO)) begin
            t_d.cnt = t_q.cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.cnt <= CNT_ZERO;
        end else begin
            t_q <= t_d;
        end
    end

    assign done = (t_q.cnt == CNT_ZERO);

endmodule

// File: rtl/nvm_pwr_fsm.sv
module nvm_pwr_fsm (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lpm,
    input  logic                     acc_req,
    input  logic                     req_bit,
    input  logic                     timer_done,
    output nvm_pwr_pkg::pwr_state_e  state,
    output logic                     timer_load,
    output logic                     hw_set
);
    import nvm_pwr_pkg::*;

    fsm_regs_t f_d, f_q;

    always_comb begin
        f_d        = f_q;
        timer_load = 1'b0;
        hw_set     = 1'b0;
        unique case (f_q.st)
            ST_ON: begin
                // an access in progress defers any power-down
                if (!acc_req && (lpm || !req_bit)) begin
                    f_d.st = ST_OFF;
                end
            end
            ST_OFF: begin
                if (acc_req) begin
                    f_d.st     = ST_WAKE;
                    timer_load = 1'b1;
                    hw_set     = 1'b1;
                end else if (!lpm && req_bit) begin
                    f_d.st     = ST_WAKE;
                    timer_load = 1'b1;
                end
            end
            ST_WAKE: begin
                if (lpm && !acc_req) begin
                    f_d.st = ST_OFF;
                end else if (timer_done) begin
                    f_d.st = ST_ON;
                end
            end
            default: f_d.st = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st <= ST_ON;
        end else begin
            f_q <= f_d;
        end
    end

    assign state = f_q.st;

endmodule

// File: rtl/nvm_pwr_ctl.sv
module nvm_pwr_ctl #(
    parameter int MODE_W = 3,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] dev_mode,
    input  logic [CNT_W-1:0]  wake_cycles,
    input  logic              reg_wr_en,
    input  logic              reg_wr_data,
    input  logic              acc_req,
    output logic              acc_grant,
    output logic              arr_pwr_en,
    output logic              pwr_req_rd
);
    import nvm_pwr_pkg::*;

    localparam logic [MODE_W-1:0] MODE_RUN = '0;
    localparam logic [CNT_W-1:0]  CNT_ZERO = '0;
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    pwr_state_e       state;
    logic             lpm;
    logic             timer_load;
    logic             timer_done;
    logic             hw_set;
    logic             req_bit;
    logic [CNT_W-1:0] load_val;

    assign lpm      = (dev_mode != MODE_RUN);
    // the wake interval counts load_val+1 cycles; a zero setting behaves as one
    assign load_val = (wake_cycles == CNT_ZERO) ? CNT_ZERO : (wake_cycles - CNT_ONE);

    nvm_req_bit u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_wr  (reg_wr_en),
        .sw_val (reg_wr_data),
        .hw_set (hw_set),
        .bit_q  (req_bit)
    );

    nvm_wake_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .run      (state == ST_WAKE),
        .load_val (load_val),
        .done     (timer_done)
    );

    nvm_pwr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lpm        (lpm),
        .acc_req    (acc_req),
        .req_bit    (req_bit),
        .timer_done (timer_done),
        .state      (state),
        .timer_load (timer_load),
        .hw_set     (hw_set)
    );

    assign acc_grant  = (state == ST_ON) && acc_req;
    assign arr_pwr_en = (state != ST_OFF);
    assign pwr_req_rd = req_bit;

endmodule

// File: rtl/nvm_pwr_chk.sv
module nvm_pwr_chk #(
    parameter int MODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] dev_mode,
    input logic              reg_wr_en,
    input logic              reg_wr_data,
    input logic              acc_req,
    input logic              acc_grant,
    input logic              arr_pwr_en,
    input logic              pwr_req_rd
);
    localparam logic [MODE_W-1:0] MODE_RUN = '0;

    assert_grant_needs_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |-> (arr_pwr_en && acc_req));

    assert_no_grant_on_powerup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_pwr_en) |-> !acc_grant);

    assert_access_sets_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!arr_pwr_en && acc_req) |=> (pwr_req_rd && arr_pwr_en));

    assert_hw_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!arr_pwr_en && acc_req && reg_wr_en && !reg_wr_data) |=> pwr_req_rd);

    assert_lpm_powers_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_mode != MODE_RUN) && !acc_req) |=> !arr_pwr_en);

    assert_bit_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_en && !acc_req) |=> $stable(pwr_req_rd));

    assert_defer_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |=> arr_pwr_en);

    assert_stay_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_pwr_en && (dev_mode == MODE_RUN) && pwr_req_rd) |=> arr_pwr_en);

endmodule

bind nvm_pwr_ctl nvm_pwr_chk #(.MODE_W(MODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_mode    (dev_mode),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .acc_req     (acc_req),
    .acc_grant   (acc_grant),
    .arr_pwr_en  (arr_pwr_en),
    .pwr_req_rd  (pwr_req_rd)
);

// File: tb/test_nvm_pwr_ctl.sv
`timescale 1ns/1ps
module test_nvm_pwr_ctl;
    localparam int MODE_W = 2;
    localparam int CNT_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [MODE_W-1:0] dev_mode;
    logic [CNT_W-1:0]  wake_cycles;
    logic              reg_wr_en;
    logic              reg_wr_data;
    logic              acc_req;
    logic              acc_grant;
    logic              arr_pwr_en;
    logic              pwr_req_rd;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    nvm_pwr_ctl #(.MODE_W(MODE_W), .CNT_W(CNT_W)) i_nvm_pwr_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_mode    (dev_mode),
        .wake_cycles (wake_cycles),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .acc_req     (acc_req),
        .acc_grant   (acc_grant),
        .arr_pwr_en  (arr_pwr_en),
        .pwr_req_rd  (pwr_req_rd)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic v);
        reg_wr_en   = 1'b1;
        reg_wr_data = v;
        step();
        reg_wr_en   = 1'b0;
    endtask

    // clear the bit with no access; array powers down two edges later
    task automatic go_off();
        sw_write(1'b0);
        step();
        step();
    endtask

    // returns number of edges from raising acc_req until grant is seen
    task automatic measure_grant(input string req, output int lat);
        lat = 0;
        for (int k = 0; k < 20; k++) begin
            if (acc_grant) break;
            step();
            lat++;
            if (!acc_grant) chk(req, int'(arr_pwr_en), 1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lat;
        int expd;
        rst_n = 1'b0; dev_mode = '0; wake_cycles = '0;
        reg_wr_en = 1'b0; reg_wr_data = 1'b0; acc_req = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        chk("R1 bit", int'(pwr_req_rd), 1);
        chk("R1 power", int'(arr_pwr_en), 1);
        acc_req = 1'b1; #1;
        chk("R1 grant", int'(acc_grant), 1);
        step(); acc_req = 1'b0; step();

        // R2: bit at 1 keeps the array on under varied access patterns
        for (int p = 0; p < 16; p++) begin
            acc_req = p[0] ^ p[2];
            step();
            chk("R2", int'(arr_pwr_en), 1);
        end
        acc_req = 1'b0; step();

        // R3: clear bit -> readback 0 after one edge, power off after two
        sw_write(1'b0);
        chk("R3 bit", int'(pwr_req_rd), 0);
        chk("R3 still on", int'(arr_pwr_en), 1);
        step();
        chk("R3 off", int'(arr_pwr_en), 0);

        // R4, R8: access-driven wake for every delay setting
        for (int d = 0; d < 8; d++) begin
            wake_cycles = CNT_W'(d);
            sw_write(1'b0); step(); step();
            chk("R3 off before sweep", int'(arr_pwr_en), 0);
            acc_req = 1'b1; #1;
            chk("R8 no grant when off", int'(acc_grant), 0);
            step();
            chk("R4 bit set", int'(pwr_req_rd), 1);
            chk("R4 waking", int'(arr_pwr_en), 1);
            lat = 1;
            if (!acc_grant) begin
                int more;
                measure_grant("R8 power in wake", more);
                lat += more;
            end
            expd = ((d == 0) ? 1 : d) + 1;
            chk("R8 access latency", lat, expd);
            acc_req = 1'b0; step();
        end

        // R5, R8: software-driven wake for every delay setting
        for (int d = 0; d < 8; d++) begin
            wake_cycles = CNT_W'(d);
            go_off();
            sw_write(1'b1);
            chk("R5 bit", int'(pwr_req_rd), 1);
            chk("R5 off yet", int'(arr_pwr_en), 0);
            step();
            chk("R5 power up", int'(arr_pwr_en), 1);
            acc_req = 1'b1; #1;
            measure_grant("R8 sw wake power", lat);
            chk("R8 sw wake latency", lat, (d == 0) ? 1 : d);
            acc_req = 1'b0; step();
        end

        // R6, R7: every low-power code with both bit values
        wake_cycles = CNT_W'(2);
        for (int m = 1; m < (1 << MODE_W); m++) begin
            for (int b = 0; b < 2; b++) begin
                sw_write(1'(b));
                repeat (6) step();
                dev_mode = MODE_W'(m);
                step();
                chk("R6 lpm off", int'(arr_pwr_en), 0);
                chk("R6 bit kept", int'(pwr_req_rd), b);
                step(); step();
                chk("R6 still off", int'(arr_pwr_en), 0);
                dev_mode = '0;
                step();
                chk("R7 return", int'(arr_pwr_en), b);
                step(); step(); step();
                chk("R7 settled", int'(arr_pwr_en), b);
                chk("R7 bit", int'(pwr_req_rd), b);
            end
        end
        sw_write(1'b1); repeat (4) step();

        // R9: access during low-power mode wakes and sets the bit
        wake_cycles = CNT_W'(3);
        sw_write(1'b0);
        dev_mode = MODE_W'(1);
        step(); step();
        chk("R6 off in lpm", int'(arr_pwr_en), 0);
        acc_req = 1'b1; #1;
        measure_grant("R9 power", lat);
        chk("R9 latency", lat, 4);
        chk("R9 bit", int'(pwr_req_rd), 1);
        step(); step();
        chk("R9 held on", int'(acc_grant), 1);
        acc_req = 1'b0;
        step();
        chk("R9 off after access", int'(arr_pwr_en), 0);
        dev_mode = '0; repeat (6) step();

        // R10: collision of software clear and hardware set
        go_off();
        chk("R10 pre off", int'(arr_pwr_en), 0);
        acc_req = 1'b1; reg_wr_en = 1'b1; reg_wr_data = 1'b0;
        step();
        reg_wr_en = 1'b0;
        chk("R10 bit", int'(pwr_req_rd), 1);
        measure_grant("R10 power", lat);
        acc_req = 1'b0; step(); step();
        chk("R10 stays on", int'(arr_pwr_en), 1);

        // R11: power-down deferred while an access is held
        acc_req = 1'b1;
        sw_write(1'b0);
        dev_mode = MODE_W'(2);
        step(); step();
        chk("R11 on", int'(arr_pwr_en), 1);
        chk("R11 grant", int'(acc_grant), 1);
        acc_req = 1'b0;
        step();
        chk("R11 off after", int'(arr_pwr_en), 0);
        dev_mode = '0; step();
        chk("R11 bit", int'(pwr_req_rd), 0);

        // R12: low-power mode during wake abandons it
        wake_cycles = CNT_W'(5);
        sw_write(1'b1);
        step();
        chk("R12 waking", int'(arr_pwr_en), 1);
        dev_mode = MODE_W'(3);
        step();
        chk("R12 abort", int'(arr_pwr_en), 0);
        dev_mode = '0;
        step();
        chk("R12 rewake", int'(arr_pwr_en), 1);
        repeat (8) step();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule